// File: doc/BRIEF.md
# Load-Use Stall Unit

This block sits between the decode and execute stages of an in-order pipeline and removes the one case that operand forwarding cannot cover. That case is an instruction that reads a register which the load just ahead of it has not yet brought back from memory. The block watches the execute-stage slot. When that slot holds a load whose destination matches a register the decode-stage instruction really reads, the block raises `hazard` for one cycle.

While `hazard` is high, the program counter and the fetch/decode buffer keep their values, so the dependent instruction is fetched and decoded again. The control bundle written into the execute slot is replaced with all zeros, which creates a bubble. The load itself moves on. On the following cycle the bubble sits in the execute slot, the condition clears, and the held instruction issues normally.

The block owns the program counter, the fetch/decode buffer (instruction word) and the decode/execute buffer (control bundle and destination register). This lets the stall sequence be observed at its ports. An external decoder reads `ifid_instr` and returns its control bundle and two source-use flags in the same cycle. Every interface here is a plain control or status pin. There is no streaming handshake, and the only back-pressure is the two write enables that the block drives itself.

Top module: `ldu_stall_unit`

## Requirements
- R1: `hazard` is high exactly when bit 0 (memory read) of `idex_ctrl` is set, `idex_rd` is nonzero, and `idex_rd` equals a used source register. Source A is `ifid_instr[19:15]`, used when `dec_use_rs1` is high. Source B is `ifid_instr[24:20]`, used when `dec_use_rs2` is high.
- R2: When bit 0 of `idex_ctrl` is clear, `hazard` stays low even if `idex_rd` matches a used source.
- R3: When `idex_rd` is zero, `hazard` stays low whatever the sources are.
- R4: A source whose use flag is low is never compared, so a match on that field alone does not raise `hazard`.
- R5: While `hazard` is high, `pc_we` and `ifid_we` are both low, and `pc` keeps its value across the next rising edge.
- R6: While `hazard` is high, `ifid_instr` keeps its value across the next rising edge.
- R7: At a rising edge with `hazard` high, `idex_ctrl` becomes all zeros. At any other edge it takes `dec_ctrl`, and `idex_rd` takes `ifid_instr[11:7]`.
- R8: A stall lasts exactly one cycle. On the cycle after it, `hazard` is low, and at the next edge the held instruction's controls enter `idex_ctrl` while `pc` advances.
- R9: Without a hazard, `pc` grows by 4 at every edge and `ifid_instr` takes `fetch_instr`.
- R10: A synchronous active-high `rst` sets `pc`, `ifid_instr`, `idex_ctrl` and `idex_rd` to zero, and `hazard` reads low in reset, including when reset arrives during a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr | input | 32 | Instruction word read at address `pc` |
| dec_ctrl | input | 8 | Control bundle decoded from `ifid_instr`; bit 0 marks a memory read |
| dec_use_rs1 | input | 1 | Decoded instruction reads source A |
| dec_use_rs2 | input | 1 | Decoded instruction reads source B |
| pc | output | 32 | Program counter |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode buffer write enable |
| hazard | output | 1 | Load-use stall in progress this cycle |
| ifid_instr | output | 32 | Instruction held in the fetch/decode buffer |
| idex_ctrl | output | 8 | Control bundle held in the decode/execute buffer |
| idex_rd | output | 5 | Destination register held in the decode/execute buffer |

## Verification
The detector is run on two-instruction sequences: a producer in the execute slot and a consumer in decode. The producer is either a load or an arithmetic operation. The consumer is a register-register op, a register-immediate op, a store or a jump. The load/arithmetic pair separates a true load-use stall from a forwardable dependency. Matches on source A, on source B, on both and on neither show that each comparator is wired to the right field. A matching field whose use flag is low, and a load into register zero, show that the gating terms are present. Directed sequences with two loads back to back and with a reset arriving mid-stall show that each stall is exactly one cycle and that reset overrides the freeze.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  // Bit positions of register fields inside an instruction word; the
  // neighbouring decoder uses the same layout.
  localparam int unsigned FLD_RD_LSB  = 7;
  localparam int unsigned FLD_RS1_LSB = 15;
  localparam int unsigned FLD_RS2_LSB = 20;
  // Number of register sources an instruction can read.
  localparam int unsigned NUM_SRC     = 2;
  // Position of the memory-read flag in the control bundle.
  localparam int unsigned MEMRD_POS   = 0;
endpackage

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect #(
  parameter int unsigned AW        = 5,
  parameter int unsigned CW        = 8,
  parameter int unsigned NSRC      = 2,
  parameter int unsigned MEMRD_BIT = 0
) (
  input  logic [CW-1:0]      ex_ctrl,
  input  logic [AW-1:0]      ex_rd,
  input  logic [NSRC*AW-1:0] src_addr,
  input  logic [NSRC-1:0]    src_use,
  output logic               stall
);
  logic [NSRC-1:0] hit;
  logic            ex_is_load;
  logic            ex_rd_live;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = src_use[i] && (src_addr[i*AW +: AW] == ex_rd);
  end

  assign ex_is_load = ex_ctrl[MEMRD_BIT];
  assign ex_rd_live = (ex_rd != '0);
  assign stall      = ex_is_load && ex_rd_live && (|hit);
endmodule

// File: rtl/ldu_ctrl_mux.sv
module ldu_ctrl_mux #(
  parameter int unsigned CW = 8
) (
  input  logic          kill,
  input  logic [CW-1:0] ctrl_in,
  output logic [CW-1:0] ctrl_out
);
  always_comb begin
    if (kill) ctrl_out = '0;
    else      ctrl_out = ctrl_in;
  end
endmodule

// File: rtl/ldu_pipe_regs.sv
module ldu_pipe_regs #(
  parameter int unsigned PCW     = 32,
  parameter int unsigned IW      = 32,
  parameter int unsigned CW      = 8,
  parameter int unsigned AW      = 5,
  parameter int unsigned PC_STEP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pc_en,
  input  logic           ifid_en,
  input  logic [IW-1:0]  fetch_word,
  input  logic [CW-1:0]  ctrl_d,
  input  logic [AW-1:0]  rd_d,
  output logic [PCW-1:0] pc_q,
  output logic [IW-1:0]  ifid_q,
  output logic [CW-1:0]  ex_ctrl_q,
  output logic [AW-1:0]  ex_rd_q
);
  localparam logic [PCW-1:0] STEP = PCW'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= '0;
    else if (pc_en) pc_q <= pc_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst)          ifid_q <= '0;
    else if (ifid_en) ifid_q <= fetch_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_ctrl_q <= '0;
      ex_rd_q   <= '0;
    end else begin
      ex_ctrl_q <= ctrl_d;
      ex_rd_q   <= rd_d;
    end
  end
endmodule

// File: rtl/ldu_stall_unit.sv
module ldu_stall_unit
  import ldu_pkg::*;
#(
  parameter int unsigned PCW     = 32,
  parameter int unsigned IW      = 32,
  parameter int unsigned CW      = 8,
  parameter int unsigned AW      = 5,
  parameter int unsigned PC_STEP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  fetch_instr,
  input  logic [CW-1:0]  dec_ctrl,
  input  logic           dec_use_rs1,
  input  logic           dec_use_rs2,
  output logic [PCW-1:0] pc,
  output logic           pc_we,
  output logic           ifid_we,
  output logic           hazard,
  output logic [IW-1:0]  ifid_instr,
  output logic [CW-1:0]  idex_ctrl,
  output logic [AW-1:0]  idex_rd
);
  localparam int unsigned NS = NUM_SRC;

  logic [NS*AW-1:0] src_fields;
  logic [NS-1:0]    src_used;
  logic [CW-1:0]    ctrl_to_ex;
  logic [AW-1:0]    dest_field;
  logic             stall_w;

  assign src_fields = {ifid_instr[FLD_RS2_LSB +: AW], ifid_instr[FLD_RS1_LSB +: AW]};
  assign src_used   = {dec_use_rs2, dec_use_rs1};
  assign dest_field = ifid_instr[FLD_RD_LSB +: AW];

  ldu_hazard_detect #(
    .AW(AW), .CW(CW), .NSRC(NS), .MEMRD_BIT(MEMRD_POS)
  ) u_detect (
    .ex_ctrl  (idex_ctrl),
    .ex_rd    (idex_rd),
    .src_addr (src_fields),
    .src_use  (src_used),
    .stall    (stall_w)
  );

  ldu_ctrl_mux #(.CW(CW)) u_mux (
    .kill     (stall_w),
    .ctrl_in  (dec_ctrl),
    .ctrl_out (ctrl_to_ex)
  );

  ldu_pipe_regs #(
    .PCW(PCW), .IW(IW), .CW(CW), .AW(AW), .PC_STEP(PC_STEP)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .pc_en      (pc_we),
    .ifid_en    (ifid_we),
    .fetch_word (fetch_instr),
    .ctrl_d     (ctrl_to_ex),
    .rd_d       (dest_field),
    .pc_q       (pc),
    .ifid_q     (ifid_instr),
    .ex_ctrl_q  (idex_ctrl),
    .ex_rd_q    (idex_rd)
  );

  assign hazard  = stall_w;
  assign pc_we   = !stall_w;
  assign ifid_we = !stall_w;
endmodule

// File: rtl/ldu_stall_checker.sv
module ldu_stall_checker #(
  parameter int unsigned PCW     = 32,
  parameter int unsigned IW      = 32,
  parameter int unsigned CW      = 8,
  parameter int unsigned AW      = 5,
  parameter int unsigned PC_STEP = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           hazard,
  input logic           pc_we,
  input logic           ifid_we,
  input logic [PCW-1:0] pc,
  input logic [IW-1:0]  ifid_instr,
  input logic [CW-1:0]  idex_ctrl,
  input logic [AW-1:0]  idex_rd,
  input logic [CW-1:0]  dec_ctrl
);
  localparam logic [PCW-1:0] STEP = PCW'(PC_STEP);

  AST_NOT_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    !idex_ctrl[0] |-> !hazard); // R2
  AST_ZERO_DEST_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (idex_rd == '0) |-> !hazard); // R3
  AST_STALL_ENABLES_LOW: assert property (@(posedge clk) disable iff (rst)
    hazard |-> (!pc_we && !ifid_we)); // R5
  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    hazard |=> (pc == $past(pc))); // R5
  AST_STALL_HOLDS_IFID: assert property (@(posedge clk) disable iff (rst)
    hazard |=> (ifid_instr == $past(ifid_instr))); // R6
  AST_BUBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    hazard |=> (idex_ctrl == '0)); // R7
  AST_CTRL_PASS: assert property (@(posedge clk) disable iff (rst)
    !hazard |=> (idex_ctrl == $past(dec_ctrl))); // R7
  AST_SINGLE_CYCLE_STALL: assert property (@(posedge clk) disable iff (rst)
    hazard |=> !hazard); // R8
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !hazard |=> (pc == $past(pc) + STEP)); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pc == '0 && ifid_instr == '0 && idex_ctrl == '0 && idex_rd == '0)); // R10
endmodule

bind ldu_stall_unit ldu_stall_checker #(
  .PCW(PCW), .IW(IW), .CW(CW), .AW(AW), .PC_STEP(PC_STEP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hazard     (hazard),
  .pc_we      (pc_we),
  .ifid_we    (ifid_we),
  .pc         (pc),
  .ifid_instr (ifid_instr),
  .idex_ctrl  (idex_ctrl),
  .idex_rd    (idex_rd),
  .dec_ctrl   (dec_ctrl)
);

// File: tb/test_ldu_stall_unit.sv
module test_ldu_stall_unit;
  localparam int CLK_PERIOD = 10;

  localparam logic [6:0] OP_LD = 7'h03;
  localparam logic [6:0] OP_RR = 7'h33;
  localparam logic [6:0] OP_RI = 7'h13;
  localparam logic [6:0] OP_ST = 7'h23;
  localparam logic [6:0] OP_JP = 7'h6F;

  // {producer_is_load, producer_rd, consumer_kind, src_a, src_b, expect_stall}
  // consumer_kind: 0 reg-reg, 1 reg-imm, 2 store, 3 jump
  localparam logic [18:0] VEC [10] = '{
    {1'b1, 5'd5,  2'd0, 5'd5,  5'd7,  1'b1},
    {1'b1, 5'd5,  2'd0, 5'd3,  5'd5,  1'b1},
    {1'b1, 5'd5,  2'd0, 5'd3,  5'd4,  1'b0},
    {1'b1, 5'd0,  2'd0, 5'd0,  5'd0,  1'b0},
    {1'b1, 5'd5,  2'd1, 5'd5,  5'd9,  1'b1},
    {1'b1, 5'd5,  2'd1, 5'd2,  5'd5,  1'b0},
    {1'b1, 5'd5,  2'd3, 5'd5,  5'd5,  1'b0},
    {1'b0, 5'd5,  2'd0, 5'd5,  5'd5,  1'b0},
    {1'b1, 5'd31, 2'd2, 5'd1,  5'd31, 1'b1},
    {1'b1, 5'd31, 2'd0, 5'd31, 5'd31, 1'b1}
  };
  localparam string VREQ [10] = '{"R1", "R1", "R1", "R3", "R4", "R4", "R4", "R2", "R1", "R1"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_instr;
  logic [7:0]  dec_ctrl;
  logic        dec_use_rs1, dec_use_rs2;
  logic [31:0] pc;
  logic        pc_we, ifid_we, hazard;
  logic [31:0] ifid_instr;
  logic [7:0]  idex_ctrl;
  logic [4:0]  idex_rd;
  logic [31:0] prog [8];
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [6:0] op, input logic [4:0] rd,
                                     input logic [4:0] a, input logic [4:0] b);
    return {7'b0, b, a, 3'b0, rd, op};
  endfunction

  function automatic logic [9:0] decode(input logic [31:0] w);
    case (w[6:0])
      OP_LD:   return {8'h03, 1'b1, 1'b0};
      OP_RR:   return {8'h12, 1'b1, 1'b1};
      OP_RI:   return {8'h22, 1'b1, 1'b0};
      OP_ST:   return {8'h04, 1'b1, 1'b1};
      OP_JP:   return {8'h42, 1'b0, 1'b0};
      default: return 10'h0;
    endcase
  endfunction

  always_comb {dec_ctrl, dec_use_rs1, dec_use_rs2} = decode(ifid_instr);
  assign fetch_instr = (pc < 32'd32) ? prog[pc[4:2]] : 32'h0;

  ldu_stall_unit i_ldu_stall_unit (
    .clk(clk), .rst(rst), .fetch_instr(fetch_instr), .dec_ctrl(dec_ctrl),
    .dec_use_rs1(dec_use_rs1), .dec_use_rs2(dec_use_rs2), .pc(pc),
    .pc_we(pc_we), .ifid_we(ifid_we), .hazard(hazard), .ifid_instr(ifid_instr),
    .idex_ctrl(idex_ctrl), .idex_rd(idex_rd)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 8; i++) prog[i] = 32'h0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [6:0] kind_op(input logic [1:0] k);
    case (k)
      2'd0:    return OP_RR;
      2'd1:    return OP_RI;
      2'd2:    return OP_ST;
      default: return OP_JP;
    endcase
  endfunction

  initial begin
    logic [31:0] dep;
    clear_prog();
    do_reset();
    rst = 1'b1;
    @(negedge clk);
    check("R10", "pc in reset", pc, 32'h0);
    check("R10", "ifid in reset", ifid_instr, 32'h0);
    check("R10", "idex ctrl in reset", {24'h0, idex_ctrl}, 32'h0);
    check("R10", "hazard in reset", {31'h0, hazard}, 32'h0);

    for (int v = 0; v < 10; v++) begin
      clear_prog();
      prog[0] = VEC[v][18] ? mk(OP_LD, VEC[v][17:13], 5'd1, 5'd0)
                           : mk(OP_RR, VEC[v][17:13], 5'd1, 5'd2);
      dep = mk(kind_op(VEC[v][12:11]), 5'd8, VEC[v][10:6], VEC[v][5:1]);
      prog[1] = dep;
      do_reset();
      @(negedge clk);
      @(negedge clk);
      check(VREQ[v], $sformatf("hazard vec %0d", v), {31'h0, hazard}, {31'h0, VEC[v][0]});
      @(negedge clk);
      if (VEC[v][0]) begin
        check("R5", "pc held", pc, 32'd8);
        check("R6", "ifid held", ifid_instr, dep);
        check("R7", "bubble ctrl", {24'h0, idex_ctrl}, 32'h0);
        check("R8", "hazard drops", {31'h0, hazard}, 32'h0);
        @(negedge clk);
        check("R8", "pc resumes", pc, 32'd12);
        check("R8", "held ctrl issues", {24'h0, idex_ctrl}, {24'h0, decode(dep)[9:2]});
      end else begin
        check("R9", "pc advances", pc, 32'd12);
        check("R7", "ctrl passes", {24'h0, idex_ctrl}, {24'h0, decode(dep)[9:2]});
        check("R9", "ifid takes next", ifid_instr, 32'h0);
      end
    end

    // back-to-back loads: each dependent load stalls once
    clear_prog();
    prog[0] = mk(OP_LD, 5'd5, 5'd1, 5'd0);
    prog[1] = mk(OP_LD, 5'd6, 5'd5, 5'd0);
    prog[2] = mk(OP_RR, 5'd7, 5'd6, 5'd2);
    do_reset();
    @(negedge clk);
    @(negedge clk);
    check("R1", "first load-use", {31'h0, hazard}, 32'h1);
    @(negedge clk);
    check("R8", "bubble cycle clear", {31'h0, hazard}, 32'h0);
    @(negedge clk);
    check("R1", "second load-use", {31'h0, hazard}, 32'h1);
    check("R7", "second load in ex", {24'h0, idex_ctrl}, 32'h03);
    @(negedge clk);
    check("R5", "pc held second stall", pc, 32'd12);

    // reset arriving during a stall
    clear_prog();
    prog[0] = mk(OP_LD, 5'd5, 5'd1, 5'd0);
    prog[1] = mk(OP_RR, 5'd8, 5'd5, 5'd5);
    do_reset();
    @(negedge clk);
    @(negedge clk);
    check("R1", "stall before reset", {31'h0, hazard}, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    check("R10", "pc after mid-stall reset", pc, 32'h0);
    check("R10", "ifid after mid-stall reset", ifid_instr, 32'h0);
    check("R10", "ctrl after mid-stall reset", {24'h0, idex_ctrl}, 32'h0);
    check("R10", "hazard after mid-stall reset", {31'h0, hazard}, 32'h0);
    rst = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule